// File: doc/BRIEF.md
# Bidirectional Alert Pin Time-Multiplexer

This block lets one open-drain, active-low thermal alert pin per channel serve as both an output and an input. A programmable prescaler divides the memory clock into a base tick of roughly 500 ns. The tick is also exported for other timers, such as bus timeouts. Each channel has a period counter that steps down once per base tick. When the counter is at zero, the next tick reloads it from the configured period.

A compare against a configured threshold splits every period into two windows. While the remaining count is above the threshold, the channel is in its drive window. The driver may then pull the pin low if that channel's local alert event is active, and the receiver is off. While the remaining count is at or below the threshold, the channel is in its sense window. The driver is off, the receiver is on, and a synchronized copy of the pin updates the channel's sensed-alert flag.

A pause request freezes every counter, and a resume request lets the counters continue from their held values. Pad circuitry and register access sit outside the block.

Top module: `alert_pin_mux`

## Requirements
- R1: `base_tick` is high for one clock out of every `cfg_prescale`+1 running clocks. The prescaler counts down from `cfg_prescale`, and the tick fires on the clock in which it holds zero.
- R2: With `cfg_prescale` equal to zero, `base_tick` is high on every running clock.
- R3: Each channel counter decrements by one on each base tick. On a tick that finds it at zero, it reloads `cfg_period`, so one period spans `cfg_period`+1 ticks.
- R4: While a channel's count is greater than `cfg_thresh` (drive window), `drv_en[i]` is high one clock later exactly when `evt_req[i]` was high, and `rcv_en[i]` is low.
- R5: While a channel's count is less than or equal to `cfg_thresh` (sense window), `drv_en[i]` is low and `rcv_en[i]` is high one clock later.
- R6: `drv_en[i]` and `rcv_en[i]` are never high together.
- R7: While `pause` is high, or after a pause until `resume` is high, no base tick occurs and all counters hold. Counting continues from the held values on the clock in which `resume` is high. If `pause` and `resume` are high together, `pause` wins.
- R8: `pin_n[i]` passes through two flops. `alert_seen[i]` takes the inverted synchronized value only on clocks where `rcv_en[i]` is high, and holds it otherwise.
- R9: During reset, all counters are zero, `drv_en`, `rcv_en` and `alert_seen` are zero, and the synchronizer flops are high. The first tick after reset loads `cfg_period`.
- R10: If `cfg_thresh` is greater than or equal to `cfg_period`, `drv_en` stays low whatever `evt_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | PRE_W | Prescaler reload value |
| cfg_period | input | CNT_W | Period counter reload value |
| cfg_thresh | input | CNT_W | Drive/sense threshold on remaining count |
| evt_req | input | NCH | Local alert event per channel |
| pin_n | input | NCH | Sampled active-low pin level per channel |
| pause | input | 1 | Freeze request |
| resume | input | 1 | Continue request |
| base_tick | output | 1 | Base tick, exported |
| drv_en | output | NCH | Output driver enable per channel |
| rcv_en | output | NCH | Receiver enable per channel |
| alert_seen | output | NCH | Sensed-alert flag per channel |

## Verification
A prescaler off by one shifts `base_tick` within its first period, which is at most `cfg_prescale`+1 clocks. A wrong period count or a wrong threshold compare moves the edges of `drv_en` and `rcv_en` by a whole tick. That mismatch appears one clock after the first tick at which the model and the design disagree. A synchronizer with the wrong depth, or a flag that updates in the drive window, changes `alert_seen` within one or two clocks of a pin edge. A pause that leaks shows as a `base_tick` pulse during the freeze, or as window edges that arrive early once counting resumes.

// File: rtl/alert_pin_mux.sv
module alert_pin_mux #(
  parameter int PRE_W = 10,
  parameter int CNT_W = 10,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [NCH-1:0]   evt_req,
  input  logic [NCH-1:0]   pin_n,
  input  logic             pause,
  input  logic             resume,
  output logic             base_tick,
  output logic [NCH-1:0]   drv_en,
  output logic [NCH-1:0]   rcv_en,
  output logic [NCH-1:0]   alert_seen
);

  logic             frozen_q;
  logic [PRE_W-1:0] pre_q;
  wire              hold = pause | (frozen_q & ~resume);

  assign base_tick = ~hold & (pre_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      pre_q    <= '0;
    end else begin
      frozen_q <= hold;
      if (!hold) pre_q <= (pre_q == '0) ? cfg_prescale : pre_q - 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt_q;
    logic             drv_q, rcv_q, s1_q, s2_q, seen_q;
    wire              in_drive = cnt_q > cfg_thresh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        drv_q  <= 1'b0;
        rcv_q  <= 1'b0;
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        seen_q <= 1'b0;
      end else begin
        if (base_tick) cnt_q <= (cnt_q == '0) ? cfg_period : cnt_q - 1'b1;
        drv_q <= in_drive & evt_req[i];
        rcv_q <= ~in_drive;
        s1_q  <= pin_n[i];
        s2_q  <= s1_q;
        if (rcv_q) seen_q <= ~s2_q;
      end
    end

    assign drv_en[i]     = drv_q;
    assign rcv_en[i]     = rcv_q;
    assign alert_seen[i] = seen_q;
  end

endmodule

module alert_pin_mux_sva #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pause,
  input logic           base_tick,
  input logic [NCH-1:0] evt_req,
  input logic [NCH-1:0] drv_en,
  input logic [NCH-1:0] rcv_en,
  input logic [NCH-1:0] alert_seen
);
  p_no_tick_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !base_tick);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_en[i] && rcv_en[i]));
    p_drive_needs_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en[i] |-> $past(evt_req[i]));
    p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rcv_en[i] |=> $stable(alert_seen[i]));
  end
endmodule

bind alert_pin_mux alert_pin_mux_sva #(.NCH(NCH)) u_sva (
  .clk(clk), .rst_n(rst_n), .pause(pause), .base_tick(base_tick),
  .evt_req(evt_req), .drv_en(drv_en), .rcv_en(rcv_en), .alert_seen(alert_seen)
);

// File: tb/sim_alert_pin_mux.sv
module sim_alert_pin_mux;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfg_prescale = 10'd3, cfg_period = 10'd9, cfg_thresh = 10'd4;
  logic [1:0] evt_req = 2'b00, pin_n = 2'b11;
  logic       pause = 1'b0, resume = 1'b0;
  logic       base_tick;
  logic [1:0] drv_en, rcv_en, alert_seen;

  int checks = 0, errors = 0;
  bit armed = 0;
  string tick_tag = "R1", drv_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_pin_mux u0 (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_period(cfg_period),
    .cfg_thresh(cfg_thresh), .evt_req(evt_req), .pin_n(pin_n), .pause(pause),
    .resume(resume), .base_tick(base_tick), .drv_en(drv_en), .rcv_en(rcv_en),
    .alert_seen(alert_seen)
  );

  int m_pre = 0, m_frz = 0;
  int m_cnt[2], m_drv[2], m_rcv[2], m_s1[2], m_s2[2], m_seen[2];

  function automatic int m_hold();
    return (pause || (m_frz != 0 && !resume)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_frz = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_drv[c] = 0; m_rcv[c] = 0; m_s1[c] = 1; m_s2[c] = 1; m_seen[c] = 0;
      end
    end else begin
      int h, t;
      h = m_hold();
      t = (h == 0 && m_pre == 0) ? 1 : 0;
      for (int c = 0; c < 2; c++) begin
        int win;
        win = (m_cnt[c] > int'(cfg_thresh)) ? 1 : 0;
        if (m_rcv[c] != 0) m_seen[c] = 1 - m_s2[c];
        m_s2[c] = m_s1[c];
        m_s1[c] = int'(pin_n[c]);
        m_drv[c] = (win != 0 && evt_req[c]) ? 1 : 0;
        m_rcv[c] = 1 - win;
        if (t != 0) m_cnt[c] = (m_cnt[c] == 0) ? int'(cfg_period) : m_cnt[c] - 1;
      end
      if (h == 0) m_pre = (m_pre == 0) ? int'(cfg_prescale) : m_pre - 1;
      m_frz = h;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk({tick_tag, " base_tick"}, int'(base_tick), (m_hold() == 0 && m_pre == 0) ? 1 : 0);
    for (int c = 0; c < 2; c++) begin
      chk({drv_tag, " drv_en"}, int'(drv_en[c]), m_drv[c]);
      chk("R5 R3 rcv_en", int'(rcv_en[c]), m_rcv[c]);
      chk("R8 alert_seen", int'(alert_seen[c]), m_seen[c]);
      chk("R6 exclusive", int'(drv_en[c] & rcv_en[c]), 0);
      if (drv_tag == "R10") chk("R10 no drive", int'(drv_en[c]), 0);
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      evt_req = {evt_req[0] ^ evt_req[1], ~evt_req[1] | evt_req[0]};
      if ((k % 3) == 0) pin_n = {pin_n[0], ~pin_n[1]};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset drv_en", int'(drv_en), 0);
    chk("R9 reset rcv_en", int'(rcv_en), 0);
    chk("R9 reset alert_seen", int'(alert_seen), 0);
    #1 rst_n = 1'b1;
    armed = 1;
    step(200);
    tick_tag = "R2"; cfg_prescale = 10'd0;
    step(150);
    tick_tag = "R7"; pause = 1'b1;
    step(1);
    pause = 1'b0;
    step(20);
    resume = 1'b1; pause = 1'b1;
    step(2);
    pause = 1'b0;
    step(1);
    resume = 1'b0;
    tick_tag = "R1"; cfg_prescale = 10'd5;
    step(120);
    drv_tag = "R10"; cfg_thresh = 10'd12; evt_req = 2'b11;
    step(3);
    evt_req = 2'b11;
    step(150);
    cfg_thresh = 10'd9;
    step(100);
    drv_tag = "R4"; cfg_thresh = 10'd2; cfg_period = 10'd7; cfg_prescale = 10'd1;
    step(200);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule